// File: doc/BRIEF.md
# Dual-Timebase Input Capture Unit

This block timestamps transitions on external input pins. Two free-running up-counters act as timebases. Four capture channels each latch the value of one of them when their input pin shows a qualifying transition. A 16-bit mode register controls the block. It decides, for each channel, which timebase that channel latches. It also holds, for each of six input pins, a two-bit code that picks which transitions count.

Every pin passes through a two-flop synchronizer and then an edge detector. The detector raises a one-cycle valid-edge pulse for every pin. For pins 1 to 4 the same pulse also loads the matching channel's capture register and raises that channel's capture strobe. Pins 0 and 5 have edge codes and edge pulses, but they have no capture channel. Software writes the mode register as a whole word, as one byte, or as one bit. Bits that a write does not address keep their value.

Top module: `dual_timebase_capture`

## Requirements
- R1: After reset the mode register, both counters, all capture registers, all edge pulses and all capture strobes are zero.
- R2: A write with wr_size_i = 0 (word) replaces all 16 mode bits with wr_data_i, visible on mode_o after the next clock.
- R3: A write with wr_size_i = 1 (byte) copies wr_data_i[7:0] into bits 7:0 when wr_sel_i = 0 and into bits 15:8 when wr_sel_i = 1. It leaves every other bit unchanged, and any other wr_sel_i value changes nothing.
- R4: A write with wr_size_i = 2 (bit) copies wr_data_i[0] into the mode bit indexed by wr_sel_i and leaves all others unchanged. A write with wr_size_i = 3 changes nothing.
- R5: Each counter increments by one on every clock where its enable bit (cnt_en_i[0] for counter 0, cnt_en_i[1] for counter 1) is high, holds otherwise, and wraps from 0xFFFF to 0.
- R6: The edge code of pin y sits in mode bits 2y+1:2y. Code 00 selects falling edges, 01 rising edges, 10 no detection and 11 both edges. A qualifying transition raises edge_o[y] for one cycle.
- R7: A pin transition set up before clock edge k produces its edge pulse and capture strobe in the cycle that follows clock edge k+2, high for exactly that cycle.
- R8: Channel c (c = 1 to 4, strobe bit c-1) uses mode bit 11+c as its timebase select: 0 picks counter 0 and 1 picks counter 1. On capture it stores the selected counter value from the cycle before the strobe rises.
- R9: Channel c is driven by pin c only. Transitions on pins 0 and 5 raise edge pulses but no capture strobe.
- R10: A capture register keeps its value until its channel captures again.
- R11: A change of an edge code applies from the next clock, and the change alone, with a steady pin, produces no edge pulse and no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en_i | input | 2 | Count enables, bit t for counter t |
| wr_en_i | input | 1 | Mode register write strobe |
| wr_size_i | input | 2 | Write size: 0 word, 1 byte, 2 bit, 3 ignored |
| wr_sel_i | input | 4 | Byte index (byte writes) or bit index (bit writes) |
| wr_data_i | input | 16 | Write data |
| pin_i | input | 6 | External capture inputs, asynchronous |
| mode_o | output | 16 | Current mode register contents |
| cnt0_o | output | 16 | Counter 0 value |
| cnt1_o | output | 16 | Counter 1 value |
| edge_o | output | 6 | One-cycle valid-edge pulse per pin |
| cap_stb_o | output | 4 | One-cycle capture strobe per channel |
| cap_val_o | output | 64 | Capture registers, channel c at bits 16c-1:16c-16 |

## Verification
The bench builds the block with its default parameters: 16-bit counters, six pins, four channels and two synchronizer stages. With 16-bit counters a wrap from 0xFFFF to 0 occurs within about 65,600 enabled cycles, so a long enabled phase makes both counters wrap and captures land on either side of the wrap. With six pins of two bits each plus four select bits, the register fills exactly 16 bits, so byte writes and bit writes reach every field, including the selects in the high byte.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

    typedef enum logic [1:0] {
        EDGE_FALL = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_NONE = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_code_e;

    typedef enum logic [1:0] {
        WR_WORD = 2'd0,
        WR_BYTE = 2'd1,
        WR_BIT  = 2'd2,
        WR_RSVD = 2'd3
    } wr_size_e;

    // qualify a detected transition against the pin's edge code
    function automatic logic edge_qualify(input logic [1:0] code,
                                          input logic       rise,
                                          input logic       fall);
        logic hit;
        unique case (edge_code_e'(code))
            EDGE_FALL: hit = fall;
            EDGE_RISE: hit = rise;
            EDGE_NONE: hit = 1'b0;
            EDGE_BOTH: hit = rise | fall;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/dtc_mode_reg.sv
module dtc_mode_reg
    import dtc_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en_i,
    input  logic [1:0]               wr_size_i,
    input  logic [$clog2(REG_W)-1:0] wr_sel_i,
    input  logic [REG_W-1:0]         wr_data_i,
    output logic [REG_W-1:0]         mode_o
);
    localparam int SEL_W   = $clog2(REG_W);
    localparam int N_BYTES = REG_W / 8;

    typedef struct packed {
        logic [REG_W-1:0] mode;
    } mr_state_t;

    mr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            unique case (wr_size_e'(wr_size_i))
                WR_WORD: st_d.mode = wr_data_i;
                WR_BYTE: begin
                    for (int b = 0; b < N_BYTES; b++) begin
                        if (wr_sel_i == SEL_W'(b)) begin
                            st_d.mode[b*8 +: 8] = wr_data_i[7:0];
                        end
                    end
                end
                WR_BIT: begin
                    for (int i = 0; i < REG_W; i++) begin
                        if (wr_sel_i == SEL_W'(i)) begin
                            st_d.mode[i] = wr_data_i[0];
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o = st_q.mode;

endmodule

// File: rtl/dtc_timebase.sv
module dtc_timebase #(
    parameter int CNT_W = 16,
    parameter int N_TB  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_TB-1:0]         en_i,
    output logic [N_TB*CNT_W-1:0]   cnt_o
);
    typedef struct packed {
        logic [N_TB-1:0][CNT_W-1:0] cnt;
    } tb_state_t;

    tb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int t = 0; t < N_TB; t++) begin
            if (en_i[t]) begin
                st_d.cnt[t] = st_q.cnt[t] + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

endmodule

// File: rtl/dtc_pin_edge.sv
module dtc_pin_edge
    import dtc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_i,
    input  logic [1:0] code_i,
    output logic       hit_o
);
    localparam int MSB = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   last;
    } pe_state_t;

    pe_state_t st_d, st_q;
    logic      rise, fall;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], pin_i};
        st_d.last = st_q.sync[MSB];
        rise      = st_q.sync[MSB] & ~st_q.last;
        fall      = ~st_q.sync[MSB] & st_q.last;
        hit_o     = edge_qualify(code_i, rise, fall);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/dtc_capture_chan.sv
module dtc_capture_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_i,
    input  logic             sel_i,
    input  logic [CNT_W-1:0] cnt0_i,
    input  logic [CNT_W-1:0] cnt1_i,
    output logic [CNT_W-1:0] val_o,
    output logic             stb_o
);
    typedef struct packed {
        logic [CNT_W-1:0] val;
        logic             stb;
    } cc_state_t;

    cc_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.stb = hit_i;
        if (hit_i) begin
            st_d.val = sel_i ? cnt1_i : cnt0_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign val_o = st_q.val;
    assign stb_o = st_q.stb;

endmodule

// File: rtl/dual_timebase_capture.sv
module dual_timebase_capture #(
    parameter int CNT_W       = 16,
    parameter int N_PINS      = 6,
    parameter int N_CH        = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [1:0]                         cnt_en_i,
    input  logic                               wr_en_i,
    input  logic [1:0]                         wr_size_i,
    input  logic [$clog2(N_CH+2*N_PINS)-1:0]   wr_sel_i,
    input  logic [N_CH+2*N_PINS-1:0]           wr_data_i,
    input  logic [N_PINS-1:0]                  pin_i,
    output logic [N_CH+2*N_PINS-1:0]           mode_o,
    output logic [CNT_W-1:0]                   cnt0_o,
    output logic [CNT_W-1:0]                   cnt1_o,
    output logic [N_PINS-1:0]                  edge_o,
    output logic [N_CH-1:0]                    cap_stb_o,
    output logic [N_CH*CNT_W-1:0]              cap_val_o
);
    localparam int REG_W  = N_CH + 2 * N_PINS;
    localparam int TB_LSB = 2 * N_PINS;
    localparam int N_TB   = 2;

    typedef struct packed {
        logic [N_PINS-1:0] hits;
    } top_state_t;

    top_state_t               st_d, st_q;
    logic [REG_W-1:0]         mode;
    logic [N_TB*CNT_W-1:0]    cnt_flat;
    logic [N_PINS-1:0]        pin_hit;

    dtc_mode_reg #(.REG_W(REG_W)) mode_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_size_i (wr_size_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .mode_o    (mode)
    );

    dtc_timebase #(.CNT_W(CNT_W), .N_TB(N_TB)) tb_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (cnt_en_i),
        .cnt_o (cnt_flat)
    );

    // one synchronizer and edge qualifier per input pin
    for (genvar y = 0; y < N_PINS; y++) begin : g_pin
        dtc_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (pin_i[y]),
            .code_i (mode[2*y +: 2]),
            .hit_o  (pin_hit[y])
        );
    end

    // channel c (index i = c-1) listens to pin c and select bit TB_LSB+i
    for (genvar i = 0; i < N_CH; i++) begin : g_chan
        dtc_capture_chan #(.CNT_W(CNT_W)) chan_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .hit_i  (pin_hit[i+1]),
            .sel_i  (mode[TB_LSB+i]),
            .cnt0_i (cnt_flat[0 +: CNT_W]),
            .cnt1_i (cnt_flat[CNT_W +: CNT_W]),
            .val_o  (cap_val_o[i*CNT_W +: CNT_W]),
            .stb_o  (cap_stb_o[i])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.hits = pin_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o = mode;
    assign cnt0_o = cnt_flat[0 +: CNT_W];
    assign cnt1_o = cnt_flat[CNT_W +: CNT_W];
    assign edge_o = st_q.hits;

endmodule

// File: rtl/dtc_checker.sv
module dtc_checker #(
    parameter int CNT_W  = 16,
    parameter int N_PINS = 6,
    parameter int N_CH   = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [1:0]                   cnt_en_i,
    input logic                         wr_en_i,
    input logic [1:0]                   wr_size_i,
    input logic [N_CH+2*N_PINS-1:0]     wr_data_i,
    input logic [N_CH+2*N_PINS-1:0]     mode_o,
    input logic [CNT_W-1:0]             cnt0_o,
    input logic [CNT_W-1:0]             cnt1_o,
    input logic [N_PINS-1:0]            edge_o,
    input logic [N_CH-1:0]              cap_stb_o,
    input logic [N_CH*CNT_W-1:0]        cap_val_o
);
    localparam int TB_LSB = 2 * N_PINS;

    // R2
    word_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_size_i == 2'd0) |=> (mode_o == $past(wr_data_i)));

    // R4
    rsvd_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_size_i == 2'd3) |=> $stable(mode_o));

    // R5
    cnt0_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_en_i[0] |=> (cnt0_o == CNT_W'($past(cnt0_o) + 1'b1)));

    // R5
    cnt1_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_en_i[1] |=> (cnt1_o == CNT_W'($past(cnt1_o) + 1'b1)));

    // R5
    cnt0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en_i[0] |=> $stable(cnt0_o));

    // R5
    cnt1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en_i[1] |=> $stable(cnt1_o));

    for (genvar y = 0; y < N_PINS; y++) begin : g_pin_chk
        // R6
        none_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_o[2*y +: 2] == 2'b10) |=> !edge_o[y]);
    end

    for (genvar i = 0; i < N_CH; i++) begin : g_chan_chk
        // R9
        strobe_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cap_stb_o[i] == edge_o[i+1]);

        // R10
        value_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !cap_stb_o[i] |-> $stable(cap_val_o[i*CNT_W +: CNT_W]));

        // R8
        timebase_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cap_stb_o[i] |-> (cap_val_o[i*CNT_W +: CNT_W] ==
                ($past(mode_o[TB_LSB+i]) ? $past(cnt1_o) : $past(cnt0_o))));
    end

endmodule

bind dual_timebase_capture dtc_checker #(
    .CNT_W  (CNT_W),
    .N_PINS (N_PINS),
    .N_CH   (N_CH)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_en_i  (cnt_en_i),
    .wr_en_i   (wr_en_i),
    .wr_size_i (wr_size_i),
    .wr_data_i (wr_data_i),
    .mode_o    (mode_o),
    .cnt0_o    (cnt0_o),
    .cnt1_o    (cnt1_o),
    .edge_o    (edge_o),
    .cap_stb_o (cap_stb_o),
    .cap_val_o (cap_val_o)
);

// File: tb/dual_timebase_capture_tb_top.sv
`timescale 1ns/1ps
module dual_timebase_capture_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cnt_en = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_size = '0;
    logic [3:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [5:0]  pins = '0;

    logic [15:0] mode_o, cnt0_o, cnt1_o;
    logic [5:0]  edge_o;
    logic [3:0]  cap_stb_o;
    logic [63:0] cap_val_o;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dual_timebase_capture dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_en_i  (cnt_en),
        .wr_en_i   (wr_en),
        .wr_size_i (wr_size),
        .wr_sel_i  (wr_sel),
        .wr_data_i (wr_data),
        .pin_i     (pins),
        .mode_o    (mode_o),
        .cnt0_o    (cnt0_o),
        .cnt1_o    (cnt1_o),
        .edge_o    (edge_o),
        .cap_stb_o (cap_stb_o),
        .cap_val_o (cap_val_o)
    );

    // reference model state, one value per design register
    logic [15:0] m_mode, m_c0, m_c1;
    logic [5:0]  m_s1, m_s2, m_last, m_edge;
    logic [3:0]  m_stb;
    logic [15:0] m_cap [4];

    function automatic logic qual(input logic [1:0] code, input logic r, input logic f);
        case (code)
            2'b00:   return f;
            2'b01:   return r;
            2'b10:   return 1'b0;
            default: return r | f;
        endcase
    endfunction

    function automatic logic [15:0] wr_apply(input logic [15:0] cur, input logic [1:0] sz,
                                             input logic [3:0] sel, input logic [15:0] d);
        logic [15:0] n = cur;
        case (sz)
            2'd0: n = d;
            2'd1: begin
                if (sel == 4'd0) n[7:0] = d[7:0];
                else if (sel == 4'd1) n[15:8] = d[7:0];
            end
            2'd2: n[sel] = d[0];
            default: ;
        endcase
        return n;
    endfunction

    task automatic model_reset();
        m_mode = '0; m_c0 = '0; m_c1 = '0;
        m_s1 = '0; m_s2 = '0; m_last = '0; m_edge = '0; m_stb = '0;
        for (int i = 0; i < 4; i++) m_cap[i] = '0;
    endtask

    task automatic model_advance();
        logic [5:0] ne;
        for (int y = 0; y < 6; y++)
            ne[y] = qual(m_mode[2*y +: 2], m_s2[y] & ~m_last[y], ~m_s2[y] & m_last[y]);
        for (int i = 0; i < 4; i++) begin
            if (ne[i+1]) m_cap[i] = m_mode[12+i] ? m_c1 : m_c0;
            m_stb[i] = ne[i+1];
        end
        m_edge = ne;
        if (wr_en) m_mode = wr_apply(m_mode, wr_size, wr_sel, wr_data);
        if (cnt_en[0]) m_c0 = m_c0 + 16'd1;
        if (cnt_en[1]) m_c1 = m_c1 + 16'd1;
        m_last = m_s2;
        m_s2 = m_s1;
        m_s1 = pins;
    endtask

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R3", "mode", {48'd0, mode_o}, {48'd0, m_mode});
        chk("R5", "cnt0", {48'd0, cnt0_o}, {48'd0, m_c0});
        chk("R5", "cnt1", {48'd0, cnt1_o}, {48'd0, m_c1});
        chk("R6", "edge", {58'd0, edge_o}, {58'd0, m_edge});
        chk("R8", "strobe", {60'd0, cap_stb_o}, {60'd0, m_stb});
        chk("R8", "values", cap_val_o, {m_cap[3], m_cap[2], m_cap[1], m_cap[0]});
    endtask

    // one clock: model follows the inputs present now, then compare at negedge
    task automatic step();
        model_advance();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic do_write(input logic [1:0] sz, input logic [3:0] sel, input logic [15:0] d);
        wr_en = 1'b1; wr_size = sz; wr_sel = sel; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    initial begin : main
        logic [15:0] held;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "mode", {48'd0, mode_o}, 64'd0);
        chk("R1", "counters", {32'd0, cnt0_o, cnt1_o}, 64'd0);
        chk("R1", "edges/strobes", {54'd0, edge_o, cap_stb_o}, 64'd0);
        chk("R1", "values", cap_val_o, 64'd0);

        // R2 word write
        do_write(2'd0, 4'd0, 16'hA5C3);
        chk("R2", "word write", {48'd0, mode_o}, 64'hA5C3);
        do_write(2'd0, 4'd0, 16'h0000);
        // R3 byte writes
        do_write(2'd1, 4'd1, 16'h779E);
        chk("R3", "high byte", {48'd0, mode_o}, 64'h9E00);
        do_write(2'd1, 4'd0, 16'h335D);
        chk("R3", "low byte", {48'd0, mode_o}, 64'h9E5D);
        do_write(2'd1, 4'd2, 16'hFFFF);
        chk("R3", "unknown byte index", {48'd0, mode_o}, 64'h9E5D);
        // R4 bit writes and ignored size
        do_write(2'd2, 4'd15, 16'hFFFE);
        chk("R4", "bit 15 clear", {48'd0, mode_o}, 64'h1E5D);
        do_write(2'd2, 4'd1, 16'h0001);
        chk("R4", "bit 1 set", {48'd0, mode_o}, 64'h1E5F);
        do_write(2'd3, 4'd0, 16'hFFFF);
        chk("R4", "reserved size", {48'd0, mode_o}, 64'h1E5F);

        // ch1 on counter 1, pin1 rising, pin0/pin5 both, pins 2..4 none
        do_write(2'd0, 4'd0, 16'h1EA7);
        cnt_en = 2'b01;
        repeat (5) step();
        cnt_en = 2'b11;
        repeat (3) step();

        // R7 latency of a rising edge on pin 1
        pins[1] = 1'b1;
        step(); chk("R7", "strobe after edge k", {63'd0, cap_stb_o[0]}, 64'd0);
        step(); chk("R7", "strobe after edge k+1", {63'd0, cap_stb_o[0]}, 64'd0);
        step(); chk("R7", "strobe after edge k+2", {63'd0, cap_stb_o[0]}, 64'd1);
        chk("R8", "ch1 took counter 1", {48'd0, cap_val_o[15:0]}, {48'd0, 16'(cnt1_o - 16'd1)});
        held = cap_val_o[15:0];
        step(); chk("R7", "strobe one cycle", {63'd0, cap_stb_o[0]}, 64'd0);

        // R9 pins 0 and 5 pulse but never capture
        pins[0] = 1'b1; pins[5] = 1'b1;
        repeat (3) step();
        chk("R9", "edge pins 0,5", {62'd0, edge_o[5], edge_o[0]}, 64'd3);
        chk("R9", "no capture", {60'd0, cap_stb_o}, 64'd0);

        // R10 falling edge under rising code: value held
        pins[1] = 1'b0;
        repeat (4) step();
        chk("R10", "ch1 value held", {48'd0, cap_val_o[15:0]}, {48'd0, held});

        // R11 code change with steady pins gives nothing
        do_write(2'd1, 4'd0, 16'h0033);
        repeat (4) begin
            step();
            chk("R11", "no pulse from code change", {54'd0, edge_o, cap_stb_o}, 64'd0);
        end
        pins[2] = 1'b1;
        repeat (3) step();
        chk("R11", "new code active", {63'd0, cap_stb_o[1]}, 64'd1);

        // long enabled phase: both counters wrap
        for (int n = 0; n < 66000; n++) begin
            cnt_en = 2'b11;
            for (int y = 0; y < 6; y++) if ($urandom_range(7) == 0) pins[y] = ~pins[y];
            if ($urandom_range(63) == 0) begin
                wr_en = 1'b1; wr_size = 2'($urandom); wr_sel = 4'($urandom); wr_data = 16'($urandom);
            end else wr_en = 1'b0;
            step();
        end
        // fully random phase
        for (int n = 0; n < 20000; n++) begin
            cnt_en = 2'($urandom);
            pins = 6'($urandom);
            wr_en = ($urandom_range(15) == 0);
            wr_size = 2'($urandom); wr_sel = 4'($urandom); wr_data = 16'($urandom);
            step();
        end
        wr_en = 1'b0;

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule